// File: doc/BRIEF.md
# Strided Vector Load/Store Unit

This block transfers one vector between a word-addressed memory and a vector register. A start pulse supplies the operation (load or store), a base word address, a signed element spacing in words, an element count and an optional per-element enable mask. The unit then walks the elements in ascending order. It issues one memory access per cycle at `base + i*stride`, with the result taken modulo the address width.

A load returns the read word one cycle after its address. The unit writes that word into element `i` of the vector register through a write port. A store reads element `i` through a combinational read port and drives it as memory write data. When the mask is enabled, an element whose mask bit is clear makes no memory access and causes no register write. A single-cycle `done` pulse closes each operation. An element count of zero makes no access and finishes straight away.

Top module: `vls_unit`

## Requirements
- R1: Element `i` (0 <= i < n) is issued in cycle `i+1` after the clock edge that accepts `start`, at address `(base + i*stride) mod 2^ADDR_W`, one element per cycle in ascending order.
- R2: On a load, each element that is issued produces `vr_wr_en` one cycle later, with `vr_wr_idx = i` and `vr_wr_data` equal to the memory word at that element's address.
- R3: On a store, each element that is issued drives `mem_we=1` and `mem_wdata` equal to vector element `i`, which is read through `vr_rd_idx = i`.
- R4: With `mask_en=1`, element `i` is active only when `mask[i]` is 1. An inactive element makes no memory access (`mem_req=0` in its cycle), makes no register write and leaves memory unchanged. With `mask_en=0` every element is active, whatever `mask` holds.
- R5: `stride` is two's-complement and signed. A negative stride walks downward with wrap-around. A zero stride accesses the same word for every element, and on a store the last active element's data remains.
- R6: `done` is high for exactly one cycle, in cycle `n+1` after the accepting edge. `busy` is high in cycles 1 to `n`.
- R7: With `vl=0` no access is made, `busy` stays low and `done` rises in cycle 1.
- R8: A `start` that arrives while `busy` is high is ignored, and the running operation continues unchanged.
- R9: After reset `busy`, `done`, `mem_req`, `mem_we` and `vr_wr_en` are low.
- R10: The element count is `n = min(vl, MAX_VL)`. A larger `vl` transfers exactly `MAX_VL` elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Signed element spacing in words |
| vl | input | VL_W | Requested element count |
| mask_en | input | 1 | Apply the per-element mask |
| mask | input | MAX_VL | Bit i enables element i |
| busy | output | 1 | Elements are being issued |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Store data |
| mem_rdata | input | WORD_W | Read data, one cycle after the address |
| vr_rd_idx | output | IDX_W | Vector element read for a store |
| vr_rd_data | input | WORD_W | Element value for vr_rd_idx |
| vr_wr_en | output | 1 | Vector element write strobe |
| vr_wr_idx | output | IDX_W | Element index written |
| vr_wr_data | output | WORD_W | Element value written |

## Verification
A corrupted address accumulator shows on `mem_addr` in the next issued element, because every address is compared with an independently computed `base + i*stride`. A wrong element counter or mask lookup shows within one cycle as an extra, missing or misplaced memory access or register write. The scoreboard pops these one by one, so nothing is lost. A fault in the stage that delays load write-back shifts `vr_wr_idx` or the data by one element, and the next write compare catches it. A faulty count register moves the `done` pulse away from cycle `n+1`.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    VLS_IDLE = 1'b0,
    VLS_RUN  = 1'b1
  } vls_state_e;
endpackage

// File: rtl/vls_seq.sv
module vls_seq
  import vls_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [VL_W-1:0]  vl,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  function automatic logic [VL_W-1:0] clamp_vl(input logic [VL_W-1:0] req);
    return (req > VL_CAP) ? VL_CAP : req;
  endfunction

  vls_state_e       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             done_q;
  logic [VL_W-1:0]  vl_eff;

  assign vl_eff = clamp_vl(vl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= VLS_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        VLS_IDLE: if (accept) begin
          if (vl_eff == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= VLS_RUN;
            idx_q   <= '0;
            last_q  <= IDX_W'(vl_eff - 1'b1);
          end
        end
        default: begin
          if (idx_q == last_q) begin
            state_q <= VLS_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state_q == VLS_RUN);
  assign idx  = idx_q;
  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q <= last_q)); // R10
endmodule

// File: rtl/vls_agen.sv
module vls_agen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] elem_addr(
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] s,
    input logic [IDX_W-1:0]  i
  );
    logic [ADDR_W+IDX_W-1:0] prod;
    prod = {{IDX_W{s[ADDR_W-1]}}, s} * (ADDR_W + IDX_W)'(i);
    return b + prod[ADDR_W-1:0];
  endfunction

  logic [ADDR_W-1:0] addr_q, base_q, stride_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      base_q   <= '0;
      stride_q <= '0;
    end else if (load) begin
      addr_q   <= base;
      base_q   <= base;
      stride_q <= stride;
    end else if (step) begin
      addr_q <= addr_q + stride_q;
    end
  end

  assign addr = addr_q;

  AST_ADDR_FORMULA: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (addr_q == elem_addr(base_q, stride_q, idx))); // R1
endmodule

// File: rtl/vls_wb.sv
module vls_wb #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rdata,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  logic             pend_q;
  logic [IDX_W-1:0] pidx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pidx_q <= '0;
    end else begin
      pend_q <= rd_fire;
      if (rd_fire) pidx_q <= rd_idx;
    end
  end

  assign wr_en   = pend_q;
  assign wr_idx  = pidx_q;
  assign wr_data = rdata;
endmodule

// File: rtl/vls_unit.sv
module vls_unit #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 16,
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int IDX_W  = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [VL_W-1:0]   vl,
  input  logic              mask_en,
  input  logic [MAX_VL-1:0] mask,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  vr_rd_idx,
  input  logic [WORD_W-1:0] vr_rd_data,
  output logic              vr_wr_en,
  output logic [IDX_W-1:0]  vr_wr_idx,
  output logic [WORD_W-1:0] vr_wr_data
);
  logic              accept, run, elem_on, rd_fire;
  logic [IDX_W-1:0]  idx;
  logic              store_q, gate_q;
  logic [MAX_VL-1:0] mask_q;

  assign accept = start && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      gate_q  <= 1'b0;
      mask_q  <= '0;
    end else if (accept) begin
      store_q <= op_store;
      gate_q  <= mask_en;
      mask_q  <= mask;
    end
  end

  vls_seq #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vl(vl),
    .busy(run), .idx(idx), .done(done)
  );

  vls_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(run),
    .base(base), .stride(stride), .idx(idx), .addr(mem_addr)
  );

  assign elem_on   = !gate_q || mask_q[idx];
  assign mem_req   = run && elem_on;
  assign mem_we    = mem_req && store_q;
  assign rd_fire   = mem_req && !store_q;
  assign mem_wdata = vr_rd_data;
  assign vr_rd_idx = idx;
  assign busy      = run;

  vls_wb #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rd_idx(idx),
    .rdata(mem_rdata), .wr_en(vr_wr_en), .wr_idx(vr_wr_idx),
    .wr_data(vr_wr_data)
  );

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    vr_wr_en |-> $past(mem_req && !mem_we)); // R2
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && gate_q && !mask_q[idx]) |-> !mem_req); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!mem_req && !mem_we)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start) |=> $stable(mask_q) && $stable(store_q)); // R8
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (run && store_q) |=> !vr_wr_en); // R3
endmodule

// File: tb/vls_unit_tb.sv
module vls_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 8;
  localparam int MAX_VL = 8;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0, op_store = 1'b0, mask_en = 1'b0;
  logic [ADDR_W-1:0] base = '0, stride = '0;
  logic [VL_W-1:0]   vl = '0;
  logic [MAX_VL-1:0] mask = '0;
  logic              busy, done, mem_req, mem_we, vr_wr_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata, vr_rd_data, vr_wr_data;
  logic [IDX_W-1:0]  vr_rd_idx, vr_wr_idx;

  logic [WORD_W-1:0] mem  [DEPTH];
  logic [WORD_W-1:0] gmem [DEPTH];
  logic [WORD_W-1:0] vreg [MAX_VL];
  logic [WORD_W-1:0] gvreg[MAX_VL];

  logic [ADDR_W-1:0] q_waddr[$], q_raddr[$];
  logic [WORD_W-1:0] q_wdata[$], q_vdata[$];
  logic [IDX_W-1:0]  q_vidx[$];

  int n_chk = 0, n_fail = 0;
  bit watchdog_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vls_unit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
    .base(base), .stride(stride), .vl(vl), .mask_en(mask_en), .mask(mask),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vr_rd_idx(vr_rd_idx), .vr_rd_data(vr_rd_data), .vr_wr_en(vr_wr_en),
    .vr_wr_idx(vr_wr_idx), .vr_wr_data(vr_wr_data)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    if (vr_wr_en) vreg[vr_wr_idx] <= vr_wr_data;
  end
  assign vr_rd_data = vreg[vr_rd_idx];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected items as the design produces them.
  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_we) begin
      if (q_waddr.size() == 0) chk(0, "R4", "unexpected mem write", WORD_W'(mem_addr), '0);
      else begin
        logic [ADDR_W-1:0] ea; logic [WORD_W-1:0] ed;
        ea = q_waddr.pop_front(); ed = q_wdata.pop_front();
        chk(mem_addr == ea, "R1", "store address", WORD_W'(mem_addr), WORD_W'(ea));
        chk(mem_wdata == ed, "R3", "store data", mem_wdata, ed);
      end
    end
    if (mem_req && !mem_we) begin
      if (q_raddr.size() == 0) chk(0, "R4", "unexpected mem read", WORD_W'(mem_addr), '0);
      else begin
        logic [ADDR_W-1:0] ea;
        ea = q_raddr.pop_front();
        chk(mem_addr == ea, "R1", "load address", WORD_W'(mem_addr), WORD_W'(ea));
      end
    end
    if (vr_wr_en) begin
      if (q_vidx.size() == 0) chk(0, "R4", "unexpected reg write", WORD_W'(vr_wr_idx), '0);
      else begin
        logic [IDX_W-1:0] ei; logic [WORD_W-1:0] ed;
        ei = q_vidx.pop_front(); ed = q_vdata.pop_front();
        chk(vr_wr_idx == ei, "R2", "load element index", WORD_W'(vr_wr_idx), WORD_W'(ei));
        chk(vr_wr_data == ed, "R2", "load data", vr_wr_data, ed);
      end
    end
  end

  // Driver: push expectations, start the operation, time the done pulse.
  task automatic run_op(input bit st, input int b, input int s, input int v,
                        input bit men, input logic [MAX_VL-1:0] m, input bit poke,
                        input string req);
    int n, k;
    bit saw_busy_ok;
    n = (v > MAX_VL) ? MAX_VL : v;
    for (int i = 0; i < n; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(b + i * s);
      if (!men || m[i]) begin
        if (st) begin
          q_waddr.push_back(a); q_wdata.push_back(gvreg[i]); gmem[a] = gvreg[i];
        end else begin
          q_raddr.push_back(a); q_vidx.push_back(IDX_W'(i));
          q_vdata.push_back(gmem[a]); gvreg[i] = gmem[a];
        end
      end
    end
    @(posedge clk); #1;
    start = 1'b1; op_store = st; base = ADDR_W'(b); stride = ADDR_W'(s);
    vl = VL_W'(v); mask_en = men; mask = m;
    @(posedge clk); #1;
    start = 1'b0; op_store = ~st; base = 8'h5a; stride = 8'h11; vl = VL_W'(3); mask = ~m;
    k = 0; saw_busy_ok = 1'b1;
    forever begin
      @(negedge clk); k++;
      if (poke && k == 2) start = 1'b1;
      if (poke && k == 3) start = 1'b0;
      if (done) break;
      if (!busy) saw_busy_ok = 1'b0;
      if (k > 4 * MAX_VL) break;
    end
    chk(k == n + 1, req, "done cycle (R6)", WORD_W'(k), WORD_W'(n + 1));
    chk(saw_busy_ok && !busy, "R6", "busy window", WORD_W'(busy), '0);
    @(negedge clk);
    chk(!done, "R6", "done single cycle", WORD_W'(done), '0);
    chk(q_waddr.size() + q_raddr.size() + q_vidx.size() == 0, req,
        "scoreboard drained", WORD_W'(q_waddr.size() + q_raddr.size() + q_vidx.size()), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    watchdog_hit = 1'b1;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]  = {32'hC0DE0000 | 32'(a), 32'(a * 7)};
      gmem[a] = mem[a];
    end
    for (int i = 0; i < MAX_VL; i++) begin
      vreg[i]  = {32'hFACE0000 | 32'(i), 32'(i * 13 + 1)};
      gvreg[i] = vreg[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !mem_req && !mem_we && !vr_wr_en, "R9", "reset outputs",
        {59'b0, busy, done, mem_req, mem_we, vr_wr_en}, '0);
    rst_n = 1'b1;

    fork
      begin
        run_op(1, 10, 1, 8, 0, '0, 0, "R3");          // contiguous store
        run_op(0, 250, 3, 8, 0, '0, 0, "R1");         // load with wrap
        run_op(1, 5, -2, 8, 1, 8'b1010_0110, 0, "R5"); // negative stride, masked store
        run_op(0, 40, 0, 5, 1, 8'b0001_0101, 0, "R4"); // zero stride, masked load
        run_op(1, 77, 0, 4, 0, '0, 0, "R5");          // zero stride store, last wins
        run_op(0, 3, 1, 0, 0, '0, 0, "R7");           // empty vector
        run_op(0, 100, 5, 12, 0, '0, 0, "R10");       // vl above MAX_VL
        run_op(1, 130, 2, 6, 0, '0, 1, "R8");         // start while busy
        run_op(0, 20, -1, 8, 0, 8'h00, 0, "R4");      // mask_en=0 ignores mask
      end
      begin
        wait (watchdog_hit);
      end
    join_any

    if (watchdog_hit) chk(0, "R6", "watchdog expired", '0, 1);
    begin
      int bad_m, bad_v;
      bad_m = 0; bad_v = 0;
      for (int a = 0; a < DEPTH; a++) if (mem[a] !== gmem[a]) bad_m++;
      for (int i = 0; i < MAX_VL; i++) if (vreg[i] !== gvreg[i]) bad_v++;
      chk(bad_m == 0, "R4", "final memory image mismatches", WORD_W'(bad_m), '0);
      chk(bad_v == 0, "R2", "final register mismatches", WORD_W'(bad_v), '0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule